// File: doc/BRIEF.md
# Instruction Queue with Shared Busy and Deferred Load Update

This block sits between a host write port and a slow instruction executor. Each host write carries an address and a data word. In queued mode every write is stored in a first-in first-out buffer, and the block hands the stored instructions to the executor one at a time, each with a single-cycle start strobe. The host can keep writing at one instruction per clock while earlier instructions are still running. In direct mode a write goes straight to the executor when the executor is free. If the executor is not free, the write is dropped.

The block asserts a busy enable whenever instructions are stored or one is running. On a board this enable would pull a shared, wired-AND busy net low. The block reads that net back through a synchronizer. A load-update request is held pending until the net is released and the block itself is idle. The update pulse then fires with no further host action, so several devices sharing the net update together.

Top module: `cmd_fifo_busy`

## Requirements
- R1: After reset, `busy_oe`, `exec_go` and `upd_pulse` are 0 and the queue is empty.
- R2: In queued mode (`fifo_en`=1), writes are accepted on consecutive cycles and issued in write order. The first write into an empty, idle block shows `exec_go` in the second cycle after its write edge.
- R3: A queued-mode write that arrives while DEPTH entries are stored is discarded. This holds even if an entry leaves in that same cycle.
- R4: Instructions start one at a time. `exec_go` is a one-cycle pulse that carries `exec_addr`/`exec_data`. Each instruction occupies EXEC_CYC cycles, so starts taken from a backlog are exactly EXEC_CYC cycles apart.
- R5: `busy_oe` is 1 while any entry is stored or an instruction is running. It falls in the cycle after the last instruction's final cycle.
- R6: Writes that arrive while an instruction is running are stored and executed later.
- R7: In direct mode (`fifo_en`=0), a write is started at its own clock edge (`exec_go` in the next cycle) when the queue is empty and the executor is in its last cycle or idle. Otherwise the write is dropped and nothing is stored.
- R8: `busy_net` passes through a two-stage synchronizer that resets to the "held low" value. A release of the net therefore takes effect on `upd_pulse` three edges later.
- R9: A high `ldac_req` sets a pending flag. `upd_pulse` is a one-cycle pulse that is raised one edge after a cycle in which the flag is set, the synchronized net is high and `busy_oe` is 0. Several requests made while the update is held off give a single pulse.
- R10: When the net is released, or when the block's own busy ends, a pending update fires by itself.
- R11: A request that arrives in the cycle in which a pending update fires leaves a new pending update, which gives a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = direct mode |
| wr_stb | input | 1 | Host write strobe, one instruction per cycle |
| wr_addr | input | 8 | Instruction address |
| wr_data | input | 14 | Instruction data word |
| exec_go | output | 1 | One-cycle start strobe to the executor |
| exec_addr | output | 8 | Address of the started instruction |
| exec_data | output | 14 | Data of the started instruction |
| busy_oe | output | 1 | 1 = pull the shared busy net low |
| busy_net | input | 1 | Level of the shared wired-AND busy net (1 = released) |
| ldac_req | input | 1 | Load-update request |
| upd_pulse | output | 1 | Deferred update strobe |

## Verification
A short burst into an idle queue checks write order and the start latency. A long unbroken burst runs while the executor drains, so the queue fills, the writes made while it is full are lost, and the accepted count drops below the offered count. Direct-mode writes, first back to back and then spaced exactly EXEC_CYC apart, show which writes are refused. Update requests are made with the net free, with the net held low by an outside agent, while the block's own queue is busy, and on two consecutive cycles. These cases separate holding from firing, merging of requests from double updates, and the three-edge synchronizer delay.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    parameter int CMD_ADDR_W = 8;
    parameter int CMD_DATA_W = 14;

    typedef struct packed {
        logic [CMD_ADDR_W-1:0] addr;
        logic [CMD_DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_QUEUE  = 2'd1,
        SRC_DIRECT = 2'd2
    } issue_src_e;

    // width of a counter that must hold values 0..n
    function automatic int ctr_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cmdq_store.sv
module cmdq_store
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_req,
    input  cmd_t wr_cmd,
    input  logic pop,
    output cmd_t head,
    output logic empty,
    output logic full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = ctr_w(DEPTH);

    cmd_t           mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CW-1:0]  cnt;
    logic           push;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    // full is judged on the stored count only; a same-cycle pop frees no slot
    assign push  = wr_req & ~full;
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_cmd;
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && !pop) |=> (full && $stable(wp)));

    // R4
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
    import cmdq_pkg::*;
#(
    parameter int EXEC_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic q_valid,
    input  cmd_t q_head,
    input  logic dir_valid,
    input  cmd_t dir_cmd,
    output logic q_pop,
    output logic go,
    output cmd_t cmd_out,
    output logic active
);
    localparam int RW = ctr_w(EXEC_CYC);

    logic [RW-1:0] rem;
    logic          free;
    issue_src_e    src;

    // free in the last cycle of a run too, so backlog starts are EXEC_CYC apart
    assign free   = (rem == '0) || (rem == RW'(1));
    assign active = (rem != '0);
    assign q_pop  = (src == SRC_QUEUE);

    always_comb begin
        src = SRC_NONE;
        if (free) begin
            if (q_valid)        src = SRC_QUEUE;
            else if (dir_valid) src = SRC_DIRECT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem     <= '0;
            go      <= 1'b0;
            cmd_out <= '0;
        end else begin
            go <= (src != SRC_NONE);
            if (src != SRC_NONE) begin
                rem     <= RW'(EXEC_CYC);
                cmd_out <= (src == SRC_QUEUE) ? q_head : dir_cmd;
            end else if (rem != '0) begin
                rem <= rem - 1'b1;
            end
        end
    end

    // R4
    go_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);

    // R4
    pop_starts_chk: assert property (@(posedge clk) disable iff (rst)
        q_pop |=> (go && active));

endmodule

// File: rtl/busy_upd.sv
module busy_upd #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic net_in,
    input  logic self_busy,
    input  logic req,
    output logic upd
);
    logic [SYNC_N-1:0] sh;
    logic              net_s;
    logic              pend;
    logic              fire;

    assign net_s = sh[SYNC_N-1];
    assign fire  = pend & net_s & ~self_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            pend <= 1'b0;
            upd  <= 1'b0;
        end else begin
            sh   <= {sh[SYNC_N-2:0], net_in};
            upd  <= fire;
            pend <= req | (pend & ~fire);
        end
    end

    // R9
    held_low_chk: assert property (@(posedge clk) disable iff (rst)
        !net_s |=> !upd);

    // R9
    held_busy_chk: assert property (@(posedge clk) disable iff (rst)
        self_busy |=> !upd);

endmodule

// File: rtl/cmd_fifo_busy.sv
module cmd_fifo_busy
    import cmdq_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int EXEC_CYC = 4,
    parameter int SYNC_N   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fifo_en,
    input  logic                  wr_stb,
    input  logic [CMD_ADDR_W-1:0] wr_addr,
    input  logic [CMD_DATA_W-1:0] wr_data,
    output logic                  exec_go,
    output logic [CMD_ADDR_W-1:0] exec_addr,
    output logic [CMD_DATA_W-1:0] exec_data,
    output logic                  busy_oe,
    input  logic                  busy_net,
    input  logic                  ldac_req,
    output logic                  upd_pulse
);
    cmd_t in_cmd, head, run_cmd;
    logic q_empty, q_full, q_pop, run_active;

    assign in_cmd = '{addr: wr_addr, data: wr_data};

    cmdq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_req (fifo_en & wr_stb),
        .wr_cmd (in_cmd),
        .pop    (q_pop),
        .head   (head),
        .empty  (q_empty),
        .full   (q_full)
    );

    cmdq_exec #(.EXEC_CYC(EXEC_CYC)) u_exec (
        .clk       (clk),
        .rst       (rst),
        .q_valid   (~q_empty),
        .q_head    (head),
        .dir_valid (~fifo_en & wr_stb & q_empty),
        .dir_cmd   (in_cmd),
        .q_pop     (q_pop),
        .go        (exec_go),
        .cmd_out   (run_cmd),
        .active    (run_active)
    );

    assign exec_addr = run_cmd.addr;
    assign exec_data = run_cmd.data;
    assign busy_oe   = ~q_empty | run_active;

    busy_upd #(.SYNC_N(SYNC_N)) u_upd (
        .clk       (clk),
        .rst       (rst),
        .net_in    (busy_net),
        .self_busy (busy_oe),
        .req       (ldac_req),
        .upd       (upd_pulse)
    );

    // R5
    busy_go_chk: assert property (@(posedge clk) disable iff (rst)
        exec_go |-> busy_oe);

    // R3
    full_busy_chk: assert property (@(posedge clk) disable iff (rst)
        q_full |-> busy_oe);

    initial begin
        assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0);
        assert (EXEC_CYC >= 2);
        assert (SYNC_N >= 2);
    end

endmodule

// File: tb/cmd_fifo_busy_test.sv
`timescale 1ns/1ps
module cmd_fifo_busy_test;
    localparam int DEPTH = 128;
    localparam int EXEC  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_en = 1'b1, wr_stb = 1'b0, ldac_req = 1'b0, ext_ok = 1'b1;
    logic [7:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic        exec_go, busy_oe, upd_pulse, busy_net;
    logic [7:0]  exec_addr;
    logic [13:0] exec_data;

    always #2.5 clk = ~clk;

    // wired-AND net: the outside agent and this block
    assign busy_net = ext_ok & ~busy_oe;

    cmd_fifo_busy uut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .exec_go(exec_go),
        .exec_addr(exec_addr), .exec_data(exec_data), .busy_oe(busy_oe),
        .busy_net(busy_net), .ldac_req(ldac_req), .upd_pulse(upd_pulse)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int qa[$], qd[$];
    int m_rem, m_ga, m_gd, m_push_cnt;
    bit m_go, m_s1, m_s2, m_pend, m_upd;

    always @(posedge clk) begin
        if (rst) begin
            qa.delete(); qd.delete();
            m_rem = 0; m_go = 0; m_s1 = 0; m_s2 = 0; m_pend = 0; m_upd = 0;
        end else begin
            bit bnow, net, full, fire;
            bnow = (qa.size() != 0) || (m_rem != 0);
            net  = ext_ok && !bnow;
            full = (qa.size() == DEPTH);
            fire = m_pend && m_s2 && !bnow;
            m_go = 0;
            if (m_rem <= 1 && qa.size() > 0) begin
                m_go = 1; m_ga = qa.pop_front(); m_gd = qd.pop_front(); m_rem = EXEC;
            end else if (m_rem <= 1 && !fifo_en && wr_stb && qa.size() == 0) begin
                m_go = 1; m_ga = wr_addr; m_gd = wr_data; m_rem = EXEC;
            end else if (m_rem > 0) begin
                m_rem--;
            end
            if (fifo_en && wr_stb && !full) begin
                qa.push_back(wr_addr); qd.push_back(wr_data); m_push_cnt++;
            end
            m_upd  = fire;
            m_pend = ldac_req || (m_pend && !fire);
            m_s2   = m_s1;
            m_s1   = net;
        end
    end

    // ---------------- per-cycle comparison ----------------
    int rtl_go_cnt = 0, rtl_upd_cnt = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit mb;
            mb = (qa.size() != 0) || (m_rem != 0);
            chk(busy_oe == mb, "R5 busy_oe", busy_oe, mb);
            chk(exec_go == m_go, "R4 exec_go", exec_go, m_go);
            if (m_go) begin
                chk(exec_addr == m_ga[7:0], "R2 exec_addr", exec_addr, m_ga);
                chk(exec_data == m_gd[13:0], "R2 exec_data", exec_data, m_gd);
            end
            chk(upd_pulse == m_upd, "R9 upd_pulse (R8 sync)", upd_pulse, m_upd);
            if (exec_go) rtl_go_cnt++;
            if (upd_pulse) rtl_upd_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input bit stb, input int a, input int d, input bit req);
        @(negedge clk);
        wr_stb = stb; wr_addr = a[7:0]; wr_data = d[13:0]; ldac_req = req;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    initial begin
        int g0, p0, u0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(busy_oe == 0, "R1 busy_oe", busy_oe, 0);
        chk(exec_go == 0, "R1 exec_go", exec_go, 0);
        chk(upd_pulse == 0, "R1 upd_pulse", upd_pulse, 0);
        idle(4);

        // R2: short burst, order and latency
        g0 = rtl_go_cnt;
        for (int i = 0; i < 6; i++) cyc(1, 16 + i, i * 291 + 5, 0);
        idle(40);
        chk(rtl_go_cnt - g0 == 6, "R2 burst started", rtl_go_cnt - g0, 6);

        // R3, R6: long burst while the executor drains
        g0 = rtl_go_cnt; p0 = m_push_cnt;
        for (int i = 0; i < 220; i++) cyc(1, i, (i * 37) & 16'h3fff, 0);
        idle(EXEC * DEPTH + 40);
        chk(rtl_go_cnt - g0 == m_push_cnt - p0, "R6 accepted all run", rtl_go_cnt - g0, m_push_cnt - p0);
        chk(m_push_cnt - p0 < 220, "R3 overflow dropped", m_push_cnt - p0, 219);
        chk(busy_oe == 0, "R5 idle after drain", busy_oe, 0);

        // R7: direct mode
        cyc(0, 0, 0, 0); fifo_en = 1'b0;
        g0 = rtl_go_cnt;
        cyc(1, 200, 1000, 0);
        cyc(1, 201, 1001, 0);
        cyc(1, 202, 1002, 0);
        idle(10);
        chk(rtl_go_cnt - g0 == 1, "R7 refused while running", rtl_go_cnt - g0, 1);
        g0 = rtl_go_cnt;
        for (int k = 0; k < 3; k++) begin
            cyc(1, 210 + k, 2000 + k, 0);
            idle(EXEC - 1);
        end
        idle(10);
        chk(rtl_go_cnt - g0 == 3, "R7 spaced writes started", rtl_go_cnt - g0, 3);
        chk(busy_oe == 0, "R7 nothing stored", busy_oe, 0);
        fifo_en = 1'b1;

        // R9: request with the net free
        u0 = rtl_upd_cnt;
        cyc(0, 0, 0, 1);
        idle(8);
        chk(rtl_upd_cnt - u0 == 1, "R9 single update", rtl_upd_cnt - u0, 1);

        // R9, R10: outside agent holds the net
        cyc(0, 0, 0, 0); ext_ok = 1'b0;
        u0 = rtl_upd_cnt;
        cyc(0, 0, 0, 1); idle(2);
        cyc(0, 0, 0, 1); idle(2);
        cyc(0, 0, 0, 1); idle(10);
        chk(rtl_upd_cnt - u0 == 0, "R9 held while net low", rtl_upd_cnt - u0, 0);
        ext_ok = 1'b1;
        idle(8);
        chk(rtl_upd_cnt - u0 == 1, "R10 fires on release", rtl_upd_cnt - u0, 1);

        // R10: deferred by own busy
        u0 = rtl_upd_cnt;
        cyc(1, 50, 500, 0);
        cyc(1, 51, 501, 1);
        cyc(1, 52, 502, 0);
        idle(6);
        chk(rtl_upd_cnt - u0 == 0, "R10 held while busy", rtl_upd_cnt - u0, 0);
        idle(30);
        chk(rtl_upd_cnt - u0 == 1, "R10 fires after busy", rtl_upd_cnt - u0, 1);

        // R11: request in the firing cycle
        u0 = rtl_upd_cnt;
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        idle(8);
        chk(rtl_upd_cnt - u0 == 2, "R11 second update", rtl_upd_cnt - u0, 2);

        // R8: three-edge delay from net release
        cyc(0, 0, 0, 0); ext_ok = 1'b0;
        cyc(0, 0, 0, 1);
        idle(5);
        ext_ok = 1'b1;
        @(negedge clk);
        chk(upd_pulse == 0, "R8 edge 1", upd_pulse, 0);
        @(negedge clk);
        chk(upd_pulse == 0, "R8 edge 2", upd_pulse, 0);
        @(negedge clk);
        chk(upd_pulse == 1, "R8 edge 3", upd_pulse, 1);
        idle(6);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule